// File: doc/BRIEF.md
# First-Order Pulse-Density Modulator DAC

This block turns a stream of signed 16-bit fractional samples into one output bit whose density of ones follows the sample value. A simple RC low-pass filter outside the chip recovers the analog level from that bit. The loop is first order. A single error integrator receives each accepted sample, minus a full-scale reference of plus or minus 1.0. The output bit selects the sign of that reference. The integrator's sign after the update becomes the new output bit.

Samples arrive on a valid/ready port. The block never applies back-pressure, because `in_ready` is held high. Every cycle in which `in_valid` is high is therefore a transfer, and it advances the modulator by one step. When `in_valid` is low, the modulator freezes. The output bit and the integrator keep their values until the next transfer. The source sets the oversampling ratio by how often it presents samples.

Top module: `pdm_dac`

## Requirements
- R1: A synchronous active-high `rst` clears the integrator to 0 and forces `dac_out` to 0. The first update after reset must therefore add +1.0 as the feedback term.
- R2: `in_ready` is 1 in every cycle. A transfer is any rising edge of `clk` at which `in_valid` is 1.
- R3: At an edge where `in_valid` is 0, `dac_out` and the integrator state do not change.
- R4: `in_data` is two's complement Q1.15, so its value is in_data/32768. On a transfer the integrator becomes acc + in_data/32768 − F. F is +1.0 when `dac_out` was 1 before the edge and −1.0 when it was 0. At the same edge `dac_out` becomes 1 if the new integrator value is zero or positive, and 0 if it is negative.
- R5: After reset, a run of zero-valued transfers produces the bit sequence 1,1,0,1,0,1,0,1.
- R6: Over any run of N consecutive transfers with k ones on `dac_out`, |2k − N − Σ in_data/32768| ≤ 6.
- R7: The integrator is 20 bits wide, with 4 integer bits including the sign and 16 fraction bits. Its arithmetic wraps modulo 2^20. For any legal input it stays within [−2.0, 2.0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on `in_data` |
| in_ready | output | 1 | Always 1; the block never back-pressures |
| in_data | input | 16 | Signed Q1.15 sample |
| dac_out | output | 1 | Pulse-density output bit |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Feedback polarity.** An inverted feedback sign makes the loop run away, so the density checks fail at once.
- **Off-by-one feedback timing.** Using the new bit instead of the registered one breaks the exact 1,1,0,1 start pattern on a zero input.
- **Idle cycles.** A design that keeps integrating while `in_valid` is low drifts away from the scoreboard, and its output moves during gaps.
- **Full-scale inputs.** At 0x7FFF and 0x8000 the integrator sits near ±2.0. A design with too little headroom would wrap there and produce a wrong density.
- **Reset taken mid-stream.** This must return the output to 0 and restore the +1.0 first step.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
  localparam int unsigned PDM_IN_W  = 16;
  localparam int unsigned PDM_INT_W = 4;

  // Fixed-point value of +1.0 for a given number of fraction bits.
  function automatic int full_scale(input int unsigned frac_bits);
    return 1 << frac_bits;
  endfunction
endpackage

// File: rtl/pdm_sample_align.sv
// Places a Q1.(IN_W-1) sample onto the integrator's binary point,
// with sign extension into the integer bits.
module pdm_sample_align #(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned ACC_W  = 20
) (
  input  logic [IN_W-1:0]         sample,
  output logic signed [ACC_W-1:0] aligned
);
  localparam int unsigned SHIFT = FRAC_W - (IN_W - 1);
  localparam int unsigned EXT   = ACC_W - IN_W - SHIFT;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign aligned = {{EXT{sample[IN_W-1]}}, sample};
    end else begin : g_shift
      assign aligned = {{EXT{sample[IN_W-1]}}, sample, {SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/pdm_integrator.sv
// Error integrator: adds the aligned sample and removes the feedback
// reference on each enabled cycle; the sum wraps in two's complement.
module pdm_integrator #(
  parameter int unsigned ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] addend,
  input  logic signed [ACC_W-1:0] fb,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_next
);
  assign acc_next = acc_q + addend - fb;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_next;
  end

  // R3: integrator frozen while no sample is transferred
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/pdm_quantizer.sv
// One-bit quantizer with its registered full-scale feedback reference.
module pdm_quantizer #(
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc_next,
  output logic                    bit_q,
  output logic signed [ACC_W-1:0] fb_q
);
  localparam logic signed [ACC_W-1:0] POS_ONE = ACC_W'(pdm_dac_pkg::full_scale(FRAC_W));
  localparam logic signed [ACC_W-1:0] NEG_ONE = -POS_ONE;

  logic next_bit;
  assign next_bit = ~acc_next[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      fb_q  <= NEG_ONE;
    end else if (en) begin
      bit_q <= next_bit;
      fb_q  <= next_bit ? POS_ONE : NEG_ONE;
    end
  end

  // R3: output bit frozen while no sample is transferred
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(bit_q));
endmodule

// File: rtl/pdm_dac.sv
module pdm_dac #(
  parameter int unsigned IN_W  = pdm_dac_pkg::PDM_IN_W,
  parameter int unsigned INT_W = pdm_dac_pkg::PDM_INT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  output logic            dac_out
);
  localparam int unsigned FRAC_W = IN_W;
  localparam int unsigned ACC_W  = INT_W + FRAC_W;
  localparam int          TWO    = 2 * pdm_dac_pkg::full_scale(FRAC_W);

  logic signed [ACC_W-1:0] sample_al, acc_q, acc_next, fb_q;
  logic                    xfer;

  assign in_ready = 1'b1;
  assign xfer     = in_valid & in_ready;

  pdm_sample_align #(.IN_W(IN_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_align (
    .sample (in_data),
    .aligned(sample_al)
  );

  pdm_integrator #(.ACC_W(ACC_W)) u_integ (
    .clk     (clk),
    .rst     (rst),
    .en      (xfer),
    .addend  (sample_al),
    .fb      (fb_q),
    .acc_q   (acc_q),
    .acc_next(acc_next)
  );

  pdm_quantizer #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_quant (
    .clk     (clk),
    .rst     (rst),
    .en      (xfer),
    .acc_next(acc_next),
    .bit_q   (dac_out),
    .fb_q    (fb_q)
  );

  // R1: first cycle after reset shows cleared state
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dac_out && acc_q == '0));

  // R4: output bit agrees with the integrator sign after every transfer
  p_sign_track_r4: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (dac_out == !acc_q[ACC_W-1]));

  // R7: negative feedback keeps the integrator inside [-2.0, 2.0)
  p_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(acc_q) >= -TWO) && (int'(acc_q) < TWO));
endmodule

// File: tb/pdm_dac_tb.sv
module pdm_dac_tb;
  localparam int ONE = 65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, dac_out;

  always #10 clk = ~clk;

  pdm_dac u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dac_out(dac_out)
  );

  int  tests = 0, fails = 0;
  bit  exp_q[$];
  int  m_acc = 0, m_fb = -ONE;
  int  ones = 0, nsent = 0;
  real ssum = 0.0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: presents one sample and pushes the expected bit (R4 model).
  task automatic send(input logic signed [15:0] x);
    bit b;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    m_acc = m_acc + 2 * int'(x) - m_fb;
    b     = (m_acc >= 0);
    m_fb  = b ? ONE : -ONE;
    exp_q.push_back(b);
    ones  += int'(b);
    nsent++;
    ssum  += real'(x) / 32768.0;
  endtask

  task automatic stop_valid();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(dac_out == 1'b0, "R1 reset output", int'(dac_out), 0);
    chk(in_ready == 1'b1, "R2 ready during reset", int'(in_ready), 1);
    rst = 1'b0;
    m_acc = 0; m_fb = -ONE;
  endtask

  task automatic win_start();
    ones = 0; nsent = 0; ssum = 0.0;
  endtask

  task automatic win_check(input string req);
    real d;
    d = 2.0 * ones - nsent - ssum;
    chk(d <= 6.0 && d >= -6.0, req, ones, $rtoi((nsent + ssum) / 2.0));
  endtask

  // Monitor: pops and compares after every transfer edge.
  always @(posedge clk) begin
    if (!rst && in_valid) begin
      #1;
      if (exp_q.size() == 0) chk(1'b0, "R4 scoreboard underflow", 0, 1);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(dac_out == e, "R4 scoreboard bit", int'(dac_out), int'(e));
        chk(in_ready == 1'b1, "R2 ready", int'(in_ready), 1);
      end
    end
  end

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit pat[8];
    pat = '{1, 1, 0, 1, 0, 1, 0, 1};
    do_reset();

    // R5: zero input pattern straight out of reset
    for (int i = 0; i < 8; i++) begin
      send(16'sd0);
      @(posedge clk); #2;
      chk(dac_out == pat[i], "R5 zero pattern", int'(dac_out), int'(pat[i]));
    end
    win_start();
    repeat (200) send(16'sd0);
    win_check("R5/R6 zero density");

    // R6: constant levels including full scale (R7 headroom)
    begin
      logic signed [15:0] lv[5];
      lv = '{16'sh4000, -16'sh6000, 16'sh7FFF, 16'sh8000, 16'sh1234};
      for (int k = 0; k < 5; k++) begin
        win_start();
        repeat (512) send(lv[k]);
        win_check("R6/R7 constant density");
      end
    end

    // R6: sampled sine, valid held high
    do_reset();
    win_start();
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 100; i++)
        repeat (32) send(16'($rtoi(0.9 * 32767.0 * $sin(6.283185307 * i / 100.0))));
    win_check("R6 sine density");

    // R3: idle gap freezes the output
    stop_valid();
    begin
      logic v;
      v = dac_out;
      repeat (10) begin
        @(negedge clk);
        chk(dac_out == v, "R3 idle hold", int'(dac_out), int'(v));
      end
    end

    // R3/R4: sine with gaps, scoreboard checks state was held
    win_start();
    for (int i = 0; i < 300; i++) begin
      send(16'($rtoi(0.7 * 32767.0 * $sin(6.283185307 * i / 50.0))));
      if (i % 3 == 0) stop_valid();
    end
    win_check("R6 gapped sine density");

    // R1: reset taken mid-stream, then first step is +1.0 again
    stop_valid();
    @(negedge clk);
    do_reset();
    send(-16'sh4000);
    @(posedge clk); #2;
    chk(dac_out == 1'b1, "R1 first step after reset", int'(dac_out), 1);
    stop_valid();
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule